// File: doc/BRIEF.md
# Three-Phase Bridge Gate-Drive Guard

This block sits between six PWM commands for a three-phase bridge (one high-side and one low-side command per leg) and the six gate-enable outputs. It cleans the commands and applies a per-leg interlock, so the two switches of a leg are never on together. It also inserts a programmable dead interval before either switch of a leg turns on. All timing is counted in cycles of one clock, and every asynchronous input first passes through a two-flop synchronizer.

Shutdown sources are ranked into tiers. An overcurrent comparator bit latches a fault. That fault turns all six gates off and pulls the active-low fault flag. It clears on its own once the comparator bit has stayed low for a programmable number of cycles. A logic-supply undervoltage flag forces everything off and flags a fault only while it is present. A high-side supply undervoltage flag on one leg blocks only that leg's high side and raises no fault. Pulling the enable low stops all gates without any fault. The overcurrent bit is ignored for a short blanking window after any gate changes state. Command and enable inputs are rejected unless they hold a new level for a set number of cycles.

Top module: `bridge_guard`

## Requirements
- R1: Bit i of each command vector belongs to leg i. `lo_cmd_n[i]` low requests `ls_on[i]`. With `HS_ACT_LOW`=1 (the default), `hi_cmd_in[i]` low requests `hs_on[i]`. With `HS_ACT_LOW`=0, a high level requests it.
- R2: `hs_on[i]` and `ls_on[i]` are never 1 in the same cycle. When a leg has both sides requested at once, both of its outputs stay off.
- R3: An output of a leg turns on only after both outputs of that leg have been off for `DEAD_CYC` consecutive cycles. A change of side therefore shows exactly `DEAD_CYC` cycles with both outputs off.
- R4: When the synchronized overcurrent bit is high outside the blanking window, a fault is latched. The latched fault drives `fault_n` low and turns off all six outputs, and it holds for as long as `oc_trip` stays high.
- R5: The latched overcurrent fault releases after `oc_trip` has been low for `CLR_CYC` consecutive synchronized cycles. Any return high restarts that count. After release the outputs follow their commands again.
- R6: `uv_logic` high forces all six outputs off and `fault_n` low. Two cycles after `uv_logic` falls, `fault_n` is high again, with no latching.
- R7: `uv_hs[i]` high forces only `hs_on[i]` off. `ls_on[i]` and the other legs keep following their commands, and `fault_n` stays high.
- R8: `en` low (after filtering) turns off all six outputs while `fault_n` stays high.
- R9: A high level of `oc_trip` that lies entirely within the `BLANK_CYC` cycles following any output change is ignored: no fault is latched and the outputs are unchanged.
- R10: A command or enable pulse shorter than `FILT_LEN` cycles has no effect on the outputs.
- R11: During reset all outputs are 0 and `fault_n` is 1. After reset no output turns on before `DEAD_CYC` cycles have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timing clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd_in | input | LEGS | High-side commands, one bit per leg (polarity set by `HS_ACT_LOW`) |
| lo_cmd_n | input | LEGS | Low-side commands, active low, one bit per leg |
| en | input | 1 | Run enable; low stops all gates silently |
| oc_trip | input | 1 | Overcurrent comparator result, high = trip |
| uv_logic | input | 1 | Logic-supply undervoltage flag, high = under |
| uv_hs | input | LEGS | Per-leg high-side supply undervoltage flags |
| hs_on | output | LEGS | High-side gate enables |
| ls_on | output | LEGS | Low-side gate enables |
| fault_n | output | 1 | Fault flag, low on overcurrent latch or logic undervoltage |

## Verification
The bench goes after a leg changing side, where a design that switched straight across would show fewer than `DEAD_CYC` off cycles or an overlap. It drives a leg with both sides requested, which a priority-based interlock would let through to one side. It tests the fault-clear timer by returning the trip bit high halfway through the count: a timer that is not restarted releases the fault too early. It also places a short trip inside the blanking window, which a design without blanking would latch, and sends sub-filter glitches that an unfiltered path would pass to the gates. A high-side undervoltage that also killed the low side or pulled the fault flag would be caught as well.

// File: rtl/gd_pkg.sv
package gd_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_state_e;

    typedef struct packed {
        logic hi_req;
        logic lo_req;
    } leg_req_t;

    // Bits needed to hold the value n (at least one).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Side a leg is heading for; conflicting requests give no side.
    function automatic leg_state_e pick_target(input leg_req_t r);
        if (r.hi_req && !r.lo_req) return LEG_HIGH;
        if (r.lo_req && !r.hi_req) return LEG_LOW;
        return LEG_OFF;
    endfunction

endpackage

// File: rtl/gd_input_cond.sv
module gd_input_cond
    import gd_pkg::*;
#(
    parameter int unsigned      WIDTH      = 1,
    parameter int unsigned      FILT_LEN   = 1,
    parameter bit               USE_FILTER = 1'b1,
    parameter logic [WIDTH-1:0] RST_VAL    = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    generate
        if (USE_FILTER) begin : g_filt
            localparam int unsigned     FW   = cnt_bits(FILT_LEN);
            localparam logic [FW-1:0]   FLIM = FW'(FILT_LEN - 1);
            for (genvar b = 0; b < int'(WIDTH); b++) begin : g_bit
                logic [FW-1:0] run_q;
                logic          held_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        run_q  <= '0;
                        held_q <= RST_VAL[b];
                    end else if (sync_q[b] == held_q) begin
                        run_q <= '0;
                    end else if (run_q == FLIM) begin
                        held_q <= sync_q[b];
                        run_q  <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end
                assign dout[b] = held_q;
            end
        end else begin : g_raw
            assign dout = sync_q;
        end
    endgenerate

endmodule

// File: rtl/gd_leg_ctrl.sv
module gd_leg_ctrl
    import gd_pkg::*;
#(
    parameter int unsigned DEAD_CYC   = 73,
    parameter bit          HS_ACT_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_f,
    input  logic lo_n_f,
    input  logic run_all,
    input  logic hs_ok,
    output logic hs_on,
    output logic ls_on,
    output logic changed
);

    localparam int unsigned   DW   = cnt_bits(DEAD_CYC);
    localparam logic [DW-1:0] DLIM = DW'(DEAD_CYC - 1);

    leg_state_e    st_q, st_d, tgt;
    logic [DW-1:0] dc_q;
    leg_req_t      req;
    logic          hi_want;

    generate
        if (HS_ACT_LOW) begin : g_hs_low
            assign hi_want = ~hi_f;
        end else begin : g_hs_high
            assign hi_want = hi_f;
        end
    endgenerate

    assign req.hi_req = hi_want & run_all & hs_ok;
    assign req.lo_req = ~lo_n_f & run_all;

    always_comb begin
        tgt  = pick_target(req);
        st_d = st_q;
        if (st_q != LEG_OFF) begin
            if (tgt != st_q) st_d = LEG_OFF;
        end else if (dc_q == DLIM) begin
            st_d = tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LEG_OFF;
            dc_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != LEG_OFF)  dc_q <= '0;
            else if (dc_q != DLIM) dc_q <= dc_q + 1'b1;
        end
    end

    assign hs_on   = (st_q == LEG_HIGH);
    assign ls_on   = (st_q == LEG_LOW);
    assign changed = (st_d != st_q);

endmodule

// File: rtl/gd_fault_ctrl.sv
module gd_fault_ctrl
    import gd_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 63,
    parameter int unsigned CLR_CYC   = 412500
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    input  logic uv_s,
    input  logic any_sw,
    output logic oc_lat,
    output logic fault_n
);

    localparam int unsigned   BW    = cnt_bits(BLANK_CYC);
    localparam logic [BW-1:0] BLOAD = BW'(BLANK_CYC);
    localparam int unsigned   CW    = cnt_bits(CLR_CYC);
    localparam logic [CW-1:0] CLIM  = CW'(CLR_CYC - 1);

    logic [BW-1:0] blank_q;
    logic [CW-1:0] clr_q;
    logic          lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= '0;
            clr_q   <= '0;
            lat_q   <= 1'b0;
        end else begin
            if (any_sw)             blank_q <= BLOAD;
            else if (blank_q != '0) blank_q <= blank_q - 1'b1;

            if (!lat_q) begin
                clr_q <= '0;
                if (oc_s && blank_q == '0) lat_q <= 1'b1;
            end else if (oc_s) begin
                clr_q <= '0;
            end else if (clr_q == CLIM) begin
                lat_q <= 1'b0;
                clr_q <= '0;
            end else begin
                clr_q <= clr_q + 1'b1;
            end
        end
    end

    assign oc_lat  = lat_q;
    assign fault_n = ~(lat_q | uv_s);

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
    import gd_pkg::*;
#(
    parameter int unsigned LEGS       = 3,
    parameter int unsigned FILT_LEN   = 10,
    parameter int unsigned DEAD_CYC   = 73,
    parameter int unsigned BLANK_CYC  = 63,
    parameter int unsigned CLR_CYC    = 412500,
    parameter bit          HS_ACT_LOW = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LEGS-1:0] hi_cmd_in,
    input  logic [LEGS-1:0] lo_cmd_n,
    input  logic            en,
    input  logic            oc_trip,
    input  logic            uv_logic,
    input  logic [LEGS-1:0] uv_hs,
    output logic [LEGS-1:0] hs_on,
    output logic [LEGS-1:0] ls_on,
    output logic            fault_n
);

    localparam int unsigned NF = 2 * LEGS + 1;
    localparam int unsigned NS = LEGS + 2;
    localparam logic [NF-1:0] FILT_RST = {1'b0, {LEGS{1'b1}}, {LEGS{HS_ACT_LOW}}};

    logic [NF-1:0]   filt_v;
    logic [NS-1:0]   sync_v;
    logic            en_f, oc_s, uv_s, oc_lat, run_all, any_sw;
    logic [LEGS-1:0] hi_f, lo_f, uvhs_s, sw;

    gd_input_cond #(
        .WIDTH(NF), .FILT_LEN(FILT_LEN), .USE_FILTER(1'b1), .RST_VAL(FILT_RST)
    ) u_cmd_cond (
        .clk(clk), .rst(rst), .din({en, lo_cmd_n, hi_cmd_in}), .dout(filt_v)
    );

    gd_input_cond #(
        .WIDTH(NS), .FILT_LEN(1), .USE_FILTER(1'b0), .RST_VAL('0)
    ) u_flag_sync (
        .clk(clk), .rst(rst), .din({uv_hs, uv_logic, oc_trip}), .dout(sync_v)
    );

    assign hi_f   = filt_v[LEGS-1:0];
    assign lo_f   = filt_v[2*LEGS-1:LEGS];
    assign en_f   = filt_v[NF-1];
    assign oc_s   = sync_v[0];
    assign uv_s   = sync_v[1];
    assign uvhs_s = sync_v[NS-1:2];

    assign run_all = en_f & ~oc_lat & ~uv_s;
    assign any_sw  = |sw;

    generate
        for (genvar g = 0; g < int'(LEGS); g++) begin : g_leg
            gd_leg_ctrl #(
                .DEAD_CYC(DEAD_CYC), .HS_ACT_LOW(HS_ACT_LOW)
            ) u_leg (
                .clk(clk), .rst(rst),
                .hi_f(hi_f[g]), .lo_n_f(lo_f[g]),
                .run_all(run_all), .hs_ok(~uvhs_s[g]),
                .hs_on(hs_on[g]), .ls_on(ls_on[g]), .changed(sw[g])
            );
        end
    endgenerate

    gd_fault_ctrl #(
        .BLANK_CYC(BLANK_CYC), .CLR_CYC(CLR_CYC)
    ) u_fault (
        .clk(clk), .rst(rst), .oc_s(oc_s), .uv_s(uv_s), .any_sw(any_sw),
        .oc_lat(oc_lat), .fault_n(fault_n)
    );

endmodule

// File: rtl/gd_checker.sv
module gd_checker #(
    parameter int unsigned LEGS     = 3,
    parameter int unsigned DEAD_CYC = 73
) (
    input logic            clk,
    input logic            rst,
    input logic [LEGS-1:0] hs_on,
    input logic [LEGS-1:0] ls_on,
    input logic            fault_n,
    input logic            en_f,
    input logic            oc_lat,
    input logic            oc_s,
    input logic [LEGS-1:0] uvhs_s
);

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        (hs_on & ls_on) == '0); // R2

    AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (!fault_n && $past(!fault_n)) |-> ((hs_on | ls_on) == '0)); // R4

    AST_OC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (oc_lat && oc_s) |=> oc_lat); // R4

    AST_EN_SILENT_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_f |=> ((hs_on | ls_on) == '0)); // R8

    AST_HS_UV_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (hs_on & $past(uvhs_s)) == '0); // R7

    generate
        for (genvar g = 0; g < int'(LEGS); g++) begin : g_gap
            int unsigned off_run;
            always_ff @(posedge clk) begin
                if (rst)                         off_run <= 0;
                else if (hs_on[g] || ls_on[g])   off_run <= 0;
                else if (off_run < DEAD_CYC)     off_run <= off_run + 1;
            end
            AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
                $rose(hs_on[g] | ls_on[g]) |-> (off_run >= DEAD_CYC)); // R3
        end
    endgenerate

endmodule

bind bridge_guard gd_checker #(.LEGS(LEGS), .DEAD_CYC(DEAD_CYC)) u_gd_chk (
    .clk(clk), .rst(rst), .hs_on(hs_on), .ls_on(ls_on), .fault_n(fault_n),
    .en_f(en_f), .oc_lat(oc_lat), .oc_s(oc_s), .uvhs_s(uvhs_s)
);

// File: tb/tb_bridge_guard.sv
module tb_bridge_guard;

    localparam int F = 3;
    localparam int D = 5;
    localparam int B = 4;
    localparam int C = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_cmd_in = 3'b111;
    logic [2:0] lo_cmd_n  = 3'b110;
    logic       en = 1'b1, oc_trip = 1'b0, uv_logic = 1'b0;
    logic [2:0] uv_hs = 3'b000;
    logic [2:0] hs_on, ls_on;
    logic       fault_n;

    int    n_tests = 0, n_fail = 0, cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R11";

    always #2 clk = ~clk;

    bridge_guard #(
        .LEGS(3), .FILT_LEN(F), .DEAD_CYC(D), .BLANK_CYC(B), .CLR_CYC(C), .HS_ACT_LOW(1'b1)
    ) dut (
        .clk(clk), .rst(rst), .hi_cmd_in(hi_cmd_in), .lo_cmd_n(lo_cmd_n), .en(en),
        .oc_trip(oc_trip), .uv_logic(uv_logic), .uv_hs(uv_hs),
        .hs_on(hs_on), .ls_on(ls_on), .fault_n(fault_n)
    );

    // Behavioural reference: integer state stepped once per rising edge.
    int f_s1[7], f_s2[7], f_val[7], f_cnt[7];
    int y_s1[5], y_s2[5];
    int lg_st[3], lg_dc[3];
    int m_blank, m_lat, m_ccnt;

    function automatic int raw_filt(int i);
        if (i < 3) return int'(hi_cmd_in[i]);
        if (i < 6) return int'(lo_cmd_n[i-3]);
        return int'(en);
    endfunction

    function automatic int raw_sync(int i);
        if (i == 0) return int'(oc_trip);
        if (i == 1) return int'(uv_logic);
        return int'(uv_hs[i-2]);
    endfunction

    always @(posedge clk) begin : mdl
        int run, hreq, lreq, tgt, any, nst[3], ndc[3], nb, nl, nc;
        if (rst) begin
            for (int i = 0; i < 7; i++) begin
                f_s1[i] = (i == 6) ? 0 : 1; f_s2[i] = f_s1[i]; f_val[i] = f_s1[i]; f_cnt[i] = 0;
            end
            for (int i = 0; i < 5; i++) begin y_s1[i] = 0; y_s2[i] = 0; end
            for (int l = 0; l < 3; l++) begin lg_st[l] = 0; lg_dc[l] = 0; end
            m_blank = 0; m_lat = 0; m_ccnt = 0;
        end else begin
            run = (f_val[6] == 1 && m_lat == 0 && y_s2[1] == 0) ? 1 : 0;
            any = 0;
            for (int l = 0; l < 3; l++) begin
                hreq = (f_val[l] == 0 && run == 1 && y_s2[2+l] == 0) ? 1 : 0;
                lreq = (f_val[3+l] == 0 && run == 1) ? 1 : 0;
                tgt  = (hreq == 1 && lreq == 0) ? 1 : ((lreq == 1 && hreq == 0) ? 2 : 0);
                if (lg_st[l] != 0) begin
                    nst[l] = (tgt != lg_st[l]) ? 0 : lg_st[l];
                    ndc[l] = 0;
                end else begin
                    nst[l] = (lg_dc[l] == D - 1) ? tgt : 0;
                    ndc[l] = (lg_dc[l] == D - 1) ? lg_dc[l] : lg_dc[l] + 1;
                end
                if (nst[l] != lg_st[l]) any = 1;
            end
            nb = any ? B : ((m_blank > 0) ? m_blank - 1 : 0);
            nl = m_lat; nc = m_ccnt;
            if (m_lat == 0) begin
                nc = 0;
                if (y_s2[0] == 1 && m_blank == 0) nl = 1;
            end else if (y_s2[0] == 1) nc = 0;
            else if (m_ccnt == C - 1) begin nl = 0; nc = 0; end
            else nc = m_ccnt + 1;
            for (int i = 0; i < 7; i++) begin
                if (f_s2[i] == f_val[i]) f_cnt[i] = 0;
                else if (f_cnt[i] == F - 1) begin f_val[i] = f_s2[i]; f_cnt[i] = 0; end
                else f_cnt[i] = f_cnt[i] + 1;
                f_s2[i] = f_s1[i]; f_s1[i] = raw_filt(i);
            end
            for (int i = 0; i < 5; i++) begin y_s2[i] = y_s1[i]; y_s1[i] = raw_sync(i); end
            for (int l = 0; l < 3; l++) begin lg_st[l] = nst[l]; lg_dc[l] = ndc[l]; end
            m_blank = nb; m_lat = nl; m_ccnt = nc;
        end
    end

    // Per-cycle comparison against the model, tagged with the current phase.
    always @(negedge clk) begin : cmp
        logic [6:0] act, exp_v;
        if (!done) begin
            for (int l = 0; l < 3; l++) begin
                exp_v[l]   = (lg_st[l] == 1);
                exp_v[3+l] = (lg_st[l] == 2);
            end
            exp_v[6] = !(m_lat != 0 || y_s2[1] != 0);
            act = {fault_n, ls_on, hs_on};
            n_tests++;
            if (act !== exp_v) begin
                n_fail++;
                $display("FAIL %s model compare: actual %b expected %b", cur_req, act, exp_v);
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin : stim
        int cnt;
        bit seen;
        tick(4);
        check("R11", "outputs in reset", int'({hs_on, ls_on}), 0);
        check("R11", "fault_n in reset", int'(fault_n), 1);
        rst = 1'b0;
        cnt = 0;
        while (ls_on[0] == 1'b0 && cnt < 50) begin tick(1); cnt++; end
        check("R11", "off cycles after reset >= dead", int'(cnt >= D), 1);

        cur_req = "R1";
        hi_cmd_in[1] = 1'b0;
        tick(20);
        check("R1", "ls_on", int'(ls_on), 3'b001);
        check("R1", "hs_on", int'(hs_on), 3'b010);

        cur_req = "R3";
        lo_cmd_n[0] = 1'b1; hi_cmd_in[0] = 1'b0;
        cnt = 0;
        while (ls_on[0] == 1'b1) tick(1);
        while (hs_on[0] == 1'b0 && cnt < 50) begin
            if (ls_on[0] == 1'b0) cnt++;
            tick(1);
        end
        check("R3", "off cycles during side change", cnt, D);
        check("R3", "hs_on after change", int'(hs_on), 3'b011);

        cur_req = "R2";
        hi_cmd_in[2] = 1'b0; lo_cmd_n[2] = 1'b0;
        tick(20);
        check("R2", "leg2 both requested", int'({hs_on[2], ls_on[2]}), 0);
        hi_cmd_in[2] = 1'b1; lo_cmd_n[2] = 1'b1;
        tick(20);

        cur_req = "R10";
        lo_cmd_n[2] = 1'b0; tick(F - 1); lo_cmd_n[2] = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin tick(1); if (ls_on[2]) seen = 1'b1; end
        check("R10", "ls_on[2] after short glitch", int'(seen), 0);
        en = 1'b0; tick(F - 1); en = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin tick(1); if (hs_on != 3'b011) seen = 1'b1; end
        check("R10", "hs_on disturbed by enable glitch", int'(seen), 0);

        cur_req = "R9";
        lo_cmd_n[2] = 1'b0;
        cnt = 0;
        while (ls_on[2] == 1'b0 && cnt < 50) begin tick(1); cnt++; end
        oc_trip = 1'b1; tick(2); oc_trip = 1'b0;
        tick(15);
        check("R9", "fault_n after blanked trip", int'(fault_n), 1);
        check("R9", "ls_on after blanked trip", int'(ls_on), 3'b100);

        cur_req = "R4";
        oc_trip = 1'b1;
        tick(30);
        check("R4", "outputs on overcurrent", int'({hs_on, ls_on}), 0);
        check("R4", "fault_n on overcurrent", int'(fault_n), 0);

        cur_req = "R5";
        oc_trip = 1'b0; tick(25);
        oc_trip = 1'b1; tick(2); oc_trip = 1'b0;
        tick(30);
        check("R5", "fault_n after restarted count", int'(fault_n), 0);
        tick(25);
        check("R5", "fault_n after full clear delay", int'(fault_n), 1);
        tick(20);
        check("R5", "hs_on restored", int'(hs_on), 3'b011);
        check("R5", "ls_on restored", int'(ls_on), 3'b100);

        cur_req = "R6";
        uv_logic = 1'b1; tick(10);
        check("R6", "outputs on logic undervoltage", int'({hs_on, ls_on}), 0);
        check("R6", "fault_n on logic undervoltage", int'(fault_n), 0);
        uv_logic = 1'b0; tick(5);
        check("R6", "fault_n after recovery", int'(fault_n), 1);
        tick(15);

        cur_req = "R7";
        uv_hs = 3'b001; tick(10);
        check("R7", "hs_on with leg0 high-side uv", int'(hs_on), 3'b010);
        check("R7", "ls_on with leg0 high-side uv", int'(ls_on), 3'b100);
        check("R7", "fault_n with high-side uv", int'(fault_n), 1);
        hi_cmd_in[0] = 1'b1; lo_cmd_n[0] = 1'b0; tick(20);
        check("R7", "ls_on[0] follows under high-side uv", int'(ls_on), 3'b101);
        uv_hs = 3'b000; tick(10);

        cur_req = "R8";
        en = 1'b0; tick(10);
        check("R8", "outputs with enable low", int'({hs_on, ls_on}), 0);
        check("R8", "fault_n with enable low", int'(fault_n), 1);
        en = 1'b1; tick(20);
        check("R8", "ls_on after enable", int'(ls_on), 3'b101);
        check("R8", "hs_on after enable", int'(hs_on), 3'b010);

        finish_run();
    end

endmodule